// File: doc/BRIEF.md
# Bi-quinary decade divider

This block is a modulus-ten counter built from two small state machines: a two-state stage (the binary stage) and a five-state stage (the quinary stage). A mode input decides which stage runs first. In counting mode the binary stage advances on every enable strobe, and each time it wraps it steps the quinary stage. The pair then reads out as an ordinary BCD up count. In square mode the quinary stage advances on every strobe, and each time it wraps it toggles the binary stage. The binary stage then is a 50% duty waveform at one tenth of the strobe rate.

The counter lives in a single clock domain. Instead of ripple clocking, an enable strobe (`step_en_i`) marks each input event. Two synchronous controls act on the stages: a clear to zero, and a preset to nine. The clear wins when both are asserted. A change of the mode input also restarts the count from zero. The divided output `div_o` is taken from a flop, so it never glitches.

Binary stage states: `BIN_LO`, `BIN_HI`. The transition is a toggle on each step.
Quinary stage states: `QUI_0` to `QUI_4`. The transitions are `QUI_n` to `QUI_n+1` on each step, with a wrap from `QUI_4` to `QUI_0`.
On any stage, clear forces `QUI_0`/`BIN_LO`, and preset forces `QUI_4`/`BIN_HI`.

Top module: `biquinary_divider`

## Requirements
- R1: While `rst_n` is low, `count_o` reads 0 and `div_o` reads 0.
- R2: `clear_i` high at a clock edge makes `count_o` 0 and `div_o` 0 after that edge, whatever the other inputs are.
- R3: `preset_nine_i` high at an edge (with no clear and no mode change) loads the value nine. `count_o` then reads 4'b1001 in counting mode and 4'b1100 in square mode.
- R4: In counting mode (`square_mode_i` = 0), each edge with `step_en_i` high advances `count_o` through the BCD values 0,1,…,9 and back to 0.
- R5: An edge with `step_en_i`, `clear_i` and `preset_nine_i` all low and an unchanged mode leaves `count_o` and `div_o` unchanged.
- R6: In square mode (`square_mode_i` = 1), `count_o[2:0]` holds the quinary stage and advances 0..4 on each strobe. `count_o[3]` holds the binary stage and toggles when the quinary stage wraps from 4 to 0.
- R7: In square mode `div_o` equals the binary stage: low for five strobes and high for five. In counting mode `div_o` is high exactly while the count is 8 or 9. `div_o` changes at the same edge as `count_o`.
- R8: An edge at which `square_mode_i` differs from its value at the previous edge (0 after reset) restarts the count at zero. This takes precedence over preset and enable.
- R9: In both modes, ten strobes starting from zero bring `count_o` back to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear_i | input | 1 | Synchronous clear to zero (highest priority) |
| preset_nine_i | input | 1 | Synchronous load of the value nine |
| step_en_i | input | 1 | Count strobe, one event per high cycle |
| square_mode_i | input | 1 | 0: BCD counting order, 1: square-wave order |
| count_o | output | 4 | Stage readout (BCD, or {binary, quinary}) |
| div_o | output | 1 | Registered divide-by-ten output |

## Verification
The block has no tuning parameters, so the bench builds it in its single configuration. With only ten states per ordering, every state, every wrap and every pairing of a control with a state is reachable within a few hundred cycles. The directed part walks both orderings through full cycles and several wraps, and collides clear with preset and with mode switches. A pseudo-random phase then mixes rare controls with frequent strobes so that a preset or a restart lands on every count value.

// File: rtl/bq_pkg.sv
package bq_pkg;
    localparam int QUI_W  = 3;
    localparam int CODE_W = QUI_W + 1;

    typedef enum logic [QUI_W-1:0] {
        QUI_0 = 3'd0,
        QUI_1 = 3'd1,
        QUI_2 = 3'd2,
        QUI_3 = 3'd3,
        QUI_4 = 3'd4
    } qui_state_t;

    typedef enum logic {
        BIN_LO = 1'b0,
        BIN_HI = 1'b1
    } bin_state_t;

    typedef enum logic {
        LINK_BCD    = 1'b0,
        LINK_SQUARE = 1'b1
    } link_t;
endpackage

// File: rtl/bq_quinary_stage.sv
module bq_quinary_stage
    import bq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear_i,
    input  logic       load_top_i,
    input  logic       step_i,
    output qui_state_t state_o,
    output qui_state_t nxt_o
);
    qui_state_t state_q;
    qui_state_t adv;

    always_comb begin
        unique case (state_q)
            QUI_0:   adv = QUI_1;
            QUI_1:   adv = QUI_2;
            QUI_2:   adv = QUI_3;
            QUI_3:   adv = QUI_4;
            QUI_4:   adv = QUI_0;
            default: adv = QUI_0;
        endcase
    end

    always_comb begin
        if (clear_i)         nxt_o = QUI_0;
        else if (load_top_i) nxt_o = QUI_4;
        else if (step_i)     nxt_o = adv;
        else                 nxt_o = state_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= QUI_0;
        else        state_q <= nxt_o;
    end

    assign state_o = state_q;

    // R6
    qui_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !clear_i && !load_top_i && state_q == QUI_4) |=> state_q == QUI_0);
endmodule

// File: rtl/bq_binary_stage.sv
module bq_binary_stage
    import bq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear_i,
    input  logic       load_top_i,
    input  logic       step_i,
    output bin_state_t state_o,
    output bin_state_t nxt_o
);
    bin_state_t state_q;
    bin_state_t flip;

    always_comb begin
        unique case (state_q)
            BIN_LO: flip = BIN_HI;
            BIN_HI: flip = BIN_LO;
        endcase
    end

    always_comb begin
        if (clear_i)         nxt_o = BIN_LO;
        else if (load_top_i) nxt_o = BIN_HI;
        else if (step_i)     nxt_o = flip;
        else                 nxt_o = state_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= BIN_LO;
        else        state_q <= nxt_o;
    end

    assign state_o = state_q;

    // R6
    bin_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !clear_i && !load_top_i) |=> state_q != $past(state_q));
endmodule

// File: rtl/biquinary_divider.sv
module biquinary_divider
    import bq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              preset_nine_i,
    input  logic              step_en_i,
    input  logic              square_mode_i,
    output logic [CODE_W-1:0] count_o,
    output logic              div_o
);
    link_t      link_q;
    link_t      link_d;
    logic       restart;
    logic       stage_clear;
    logic       qui_step;
    logic       bin_step;
    qui_state_t qui_state;
    qui_state_t qui_nxt;
    bin_state_t bin_state;
    bin_state_t bin_nxt;
    logic       div_d;

    assign link_d      = link_t'(square_mode_i);
    assign restart     = (link_d != link_q);
    assign stage_clear = clear_i || restart;

    // Stage linking: which stage takes the strobe, which takes the wrap
    always_comb begin
        unique case (link_q)
            LINK_BCD: begin
                bin_step = step_en_i;
                qui_step = step_en_i && (bin_state == BIN_HI);
            end
            LINK_SQUARE: begin
                qui_step = step_en_i;
                bin_step = step_en_i && (qui_state == QUI_4);
            end
        endcase
    end

    bq_quinary_stage u_qui (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (stage_clear),
        .load_top_i (preset_nine_i),
        .step_i     (qui_step),
        .state_o    (qui_state),
        .nxt_o      (qui_nxt)
    );

    bq_binary_stage u_bin (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (stage_clear),
        .load_top_i (preset_nine_i),
        .step_i     (bin_step),
        .state_o    (bin_state),
        .nxt_o      (bin_nxt)
    );

    // Mode register and registered divided output
    always_comb begin
        unique case (link_d)
            LINK_BCD:    div_d = (qui_nxt == QUI_4);
            LINK_SQUARE: div_d = (bin_nxt == BIN_HI);
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            link_q <= LINK_BCD;
            div_o  <= 1'b0;
        end else begin
            link_q <= link_d;
            div_o  <= div_d;
        end
    end

    // Readout routing
    always_comb begin
        unique case (link_q)
            LINK_BCD:    count_o = {qui_state[QUI_W-1:0], bin_state};
            LINK_SQUARE: count_o = {bin_state, qui_state[QUI_W-1:0]};
        endcase
    end

    // R2
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (count_o == '0) && !div_o);

    // R3
    preset_nine_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (preset_nine_i && !clear_i && !restart) |=>
            count_o == ((link_q == LINK_SQUARE) ? 4'b1100 : 4'b1001));

    // R8
    mode_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i && restart) |=> count_o == '0);

    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i && !preset_nine_i && !step_en_i && !restart) |=>
            $stable(count_o) && $stable(div_o));

    // R4
    bcd_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (link_q == LINK_BCD && !restart && step_en_i && !clear_i && !preset_nine_i) |=>
            count_o == (($past(count_o) == 4'd9) ? 4'd0 : $past(count_o) + 4'd1));

    // R7
    square_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (link_q == LINK_SQUARE) |-> div_o == count_o[3]);

    // R7
    bcd_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (link_q == LINK_BCD) |-> div_o == (count_o >= 4'd8));
endmodule

// File: tb/tb_biquinary_divider.sv
module tb_biquinary_divider;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clear_i = 1'b0;
    logic       preset_nine_i = 1'b0;
    logic       step_en_i = 1'b0;
    logic       square_mode_i = 1'b0;
    logic [3:0] count_o;
    logic       div_o;

    int vectors = 0;
    int fails   = 0;
    int mval    = 0;   // model count value 0..9
    int mprev   = 0;   // model mode seen at previous edge
    string last_tag = "R1";

    always #4 clk = ~clk;

    biquinary_divider dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .clear_i       (clear_i),
        .preset_nine_i (preset_nine_i),
        .step_en_i     (step_en_i),
        .square_mode_i (square_mode_i),
        .count_o       (count_o),
        .div_o         (div_o)
    );

    function automatic logic [3:0] exp_code(input int v, input int m);
        if (m == 0) return 4'(v);
        return {(v >= 5) ? 1'b1 : 1'b0, 3'(v % 5)};
    endfunction

    function automatic logic exp_div(input int v, input int m);
        if (m == 0) return (v >= 8);
        return (v >= 5);
    endfunction

    // Behavioural reference, updated at each rising edge
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mval = 0; mprev = 0; last_tag = "R1";
        end else begin
            if (clear_i) begin
                mval = 0; last_tag = "R2";
            end else if (int'(square_mode_i) != mprev) begin
                mval = 0; last_tag = "R8";
            end else if (preset_nine_i) begin
                mval = 9; last_tag = "R3";
            end else if (step_en_i) begin
                mval = (mval + 1) % 10;
                last_tag = (mprev == 0) ? "R4" : "R6";
            end else begin
                last_tag = "R5";
            end
            mprev = int'(square_mode_i);
        end
    end

    task automatic compare(input string tag);
        logic [3:0] ec;
        logic       ed;
        ec = exp_code(mval, mprev);
        ed = exp_div(mval, mprev);
        vectors++;
        if (count_o !== ec) begin
            fails++;
            $display("FAIL %s count_o actual=%b expected=%b", tag, count_o, ec);
        end
        if (div_o !== ed) begin
            fails++;
            $display("FAIL R7 (%s) div_o actual=%b expected=%b", tag, div_o, ed);
        end
    endtask

    task automatic apply(input logic e, input logic c, input logic s, input logic m);
        step_en_i = e; clear_i = c; preset_nine_i = s; square_mode_i = m;
        @(posedge clk);
        @(negedge clk);
        compare(last_tag);
    endtask

    task automatic check_zero_r9(input int m);
        vectors++;
        if (count_o !== 4'd0) begin
            fails++;
            $display("FAIL R9 mode=%0d ten strobes actual=%b expected=0000", m, count_o);
        end
    endtask

    task automatic summary;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual=timeout expected=run complete");
        summary();
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (2) @(negedge clk);
        compare("R1");
        apply(1, 0, 0, 0);
        compare("R1");
        rst_n = 1'b1;

        // R4 / R5: counting order with idle gaps
        for (int i = 0; i < 26; i++) apply((i % 4) != 3, 0, 0, 0);
        apply(0, 0, 1, 0);             // R3 preset in counting mode
        apply(1, 0, 0, 0);             // 9 -> 0 wrap
        apply(1, 0, 1, 0);             // R3 preset beats enable
        apply(1, 1, 1, 0);             // R2 clear beats preset
        apply(1, 0, 0, 0);
        apply(1, 0, 0, 0);
        apply(0, 1, 0, 0);             // R2 clear mid-count

        // R9 counting order
        for (int i = 0; i < 10; i++) apply(1, 0, 0, 0);
        check_zero_r9(0);

        // R8: restart on switch, preset and enable both ignored
        apply(1, 0, 0, 0);
        apply(1, 0, 0, 0);
        apply(1, 0, 1, 1);

        // R6 / R7: square order
        for (int i = 0; i < 33; i++) apply((i % 7) != 6, 0, 0, 1);
        apply(1, 1, 0, 1);             // R2 clear
        for (int i = 0; i < 10; i++) apply(1, 0, 0, 1);
        check_zero_r9(1);
        apply(0, 0, 1, 1);             // R3 preset in square mode
        apply(1, 0, 0, 1);             // wraps to 0
        apply(1, 0, 0, 1);
        apply(1, 0, 0, 1);
        apply(1, 0, 0, 0);             // R8 switch back mid-count
        apply(1, 1, 0, 1);             // R2 clear with mode change

        // Mixed traffic
        for (int i = 0; i < 400; i++) begin
            int r;
            logic m_next;
            r = int'($urandom % 100);
            m_next = square_mode_i;
            if (r >= 97) m_next = ~square_mode_i;
            apply((r % 3) != 0, (r < 3), (r >= 3 && r < 8), m_next);
        end

        // R1: asynchronous reset mid-run
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        vectors++;
        if (count_o !== 4'd0 || div_o !== 1'b0) begin
            fails++;
            $display("FAIL R1 async reset actual=%b/%b expected=0000/0", count_o, div_o);
        end
        @(negedge clk);
        rst_n = 1'b1;
        apply(1, 0, 0, 0);
        apply(1, 0, 0, 0);

        summary();
        $finish;
    end
endmodule